// File: doc/BRIEF.md
# Bus-Snooping Serial Access Sequencer

This block sits beside a bytewide static memory and watches the memory's chip enable, output enable and write enable strobes, all active low. While it is locked it does not get in the way: the memory's enable follows the bus enable. Meanwhile it compares data bit 0 of every write against a fixed 64-bit unlock key. Writing the whole key in order, with no read in between, unlocks the block. The next 64 bus cycles then go to eight hidden 8-bit registers instead of the memory. Each cycle moves one bit. A write cycle stores the bit taken from data bit 0, and a read cycle drives the stored bit back onto data bit 0.

The strobes come from outside the clock domain. They pass through two-flop synchronizers, and a bus cycle is recognised on the falling edge of the synchronized chip enable. A reset pin and a power-fail flag can end an unlocked session early. The reset pin can be locked out by a bit inside the hidden registers. A mode input selects whether the memory is treated as read-only or as writable while power fails. A registered host port reads any hidden register byte.

Top module: `snoop_unlock_seq`

## Requirements
- R1: While locked and power is good, `mem_ce_n` follows `bus_ce_n`, delayed by the synchronizer and one register.
- R2: The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C. It is consumed first byte first, and each byte from bit 0 up to bit 7. A write whose data bit 0 equals the current key bit advances the key position. The 64th matching write unlocks the block. That 64th write still reaches the memory, but every later transfer cycle holds `mem_ce_n` high for its whole length.
- R3: A write that misses the key bit freezes the key position. All later writes are ignored, even a complete correct key, until a read cycle occurs.
- R4: Any read cycle while locked returns the key position to bit 0.
- R5: In a write transfer cycle with transfer index k (0..63), the bit on `bus_d0_in` is stored into register byte k/8 at bit position k%8.
- R6: In a read transfer cycle with index k, the block drives bit k%8 of register byte k/8 on `bus_d0_out`. It asserts `bus_d0_oe` only while both `bus_ce_n` and `bus_oe_n` are low, and never while the memory is enabled.
- R7: The block locks again after the 64th transfer cycle. Reads and writes may be mixed during a transfer. A partial transfer leaves the block unlocked.
- R8: Strobe activity while `bus_ce_n` is high does not count as a bus cycle and disturbs neither the key match nor the transfer.
- R9: A low level on `bus_rst_n` ends an unlocked session and clears the key position, but only while bit 4 of register byte 4 is 0. When that bit is 1 the pin has no effect.
- R10: While `pwr_fail` is high, `mem_ce_n` is forced low when `rom_sel` is 1 and forced high when `rom_sel` is 0. Power fail also ends an unlocked session.
- R11: `rf_data` returns register byte `rf_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_d0_in | input | 1 | Data bit 0 from the bus |
| bus_rst_n | input | 1 | Session abort pin, active low |
| rom_sel | input | 1 | 1 selects read-only memory handling |
| pwr_fail | input | 1 | Supply out of tolerance |
| mem_ce_n | output | 1 | Chip enable to the memory, active low |
| bus_d0_out | output | 1 | Data bit 0 driven in read transfers |
| bus_d0_oe | output | 1 | Drive enable for bus_d0_out |
| rf_addr | input | 3 | Host read byte address |
| rf_data | output | 8 | Host read byte data |

## Verification
Two functions can fall in the same cycle. The last matching key write lands in the same cycle as the mode change, and the last transfer cycle lands in the same cycle as the return to locked. The memory enable has to be decided from the mode that held when the cycle began. The bench checks the memory enable in the middle of the cycle right after an unlock and the cycle right after a full transfer. An abort from the reset pin or from power fail is also raised partway through a transfer. The bench then looks at whether the next cycle reaches the memory, comparing with a bench-side model of the key position and the transfer index.

// File: rtl/sus_pkg.sv
package sus_pkg;
  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_RD = 2'd1, EV_WR = 2'd2} ev_t;
  typedef enum logic {M_MATCH = 1'b0, M_ACCESS = 1'b1} mode_t;

  // Four-byte motif repeated twice; byte 0 sits in the low bits.
  function automatic logic [63:0] build_key();
    logic [63:0] k;
    logic [7:0]  motif [4];
    motif[0] = 8'hC5; motif[1] = 8'h3A; motif[2] = 8'hA3; motif[3] = 8'h5C;
    for (int i = 0; i < 8; i++) k[i*8 +: 8] = motif[i % 4];
    return k;
  endfunction

  localparam logic [63:0] KEY_DEFAULT = build_key();
endpackage

// File: rtl/sus_sync.sv
module sus_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sus_evt.sv
module sus_evt
  import sus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce_s,
  input  logic oe_s,
  input  logic we_s,
  output logic fall,
  output ev_t  ev
);
  logic ce_q;
  always_ff @(posedge clk) begin
    if (rst) ce_q <= 1'b1;
    else     ce_q <= ce_s;
  end

  // A bus cycle begins when the synchronized enable drops.
  assign fall = ce_q & ~ce_s;

  always_comb begin
    ev = EV_NONE;
    if (fall) begin
      if (!we_s)      ev = EV_WR;
      else if (!oe_s) ev = EV_RD;
    end
  end
endmodule

// File: rtl/sus_ctrl.sv
module sus_ctrl
  import sus_pkg::*;
#(
  parameter int                KEY_BITS  = 64,
  parameter logic [KEY_BITS-1:0] KEY     = KEY_DEFAULT,
  parameter int                XFER_BITS = 64,
  localparam int               PW        = $clog2(KEY_BITS),
  localparam int               XW        = $clog2(XFER_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  ev_t           ev,
  input  logic          d0,
  input  logic          abort,
  input  logic          pf,
  output logic          in_access,
  output logic [PW-1:0] key_ptr,
  output logic          miss,
  output logic [XW-1:0] xfer_idx,
  output logic          xfer_wr,
  output logic          xfer_rd
);
  mode_t mode;

  assign in_access = (mode == M_ACCESS);
  assign xfer_wr   = in_access && (ev == EV_WR) && !pf && !abort;
  assign xfer_rd   = in_access && (ev == EV_RD) && !pf && !abort;

  always_ff @(posedge clk) begin
    if (rst || pf || abort) begin
      mode     <= M_MATCH;
      key_ptr  <= '0;
      miss     <= 1'b0;
      xfer_idx <= '0;
    end else if (mode == M_MATCH) begin
      if (ev == EV_RD) begin
        key_ptr <= '0;
        miss    <= 1'b0;
      end else if (ev == EV_WR && !miss) begin
        if (d0 == KEY[key_ptr]) begin
          if (key_ptr == PW'(KEY_BITS - 1)) begin
            mode     <= M_ACCESS;
            key_ptr  <= '0;
            xfer_idx <= '0;
          end else begin
            key_ptr <= key_ptr + 1'b1;
          end
        end else begin
          miss <= 1'b1;
        end
      end
    end else begin
      if (ev != EV_NONE) begin
        if (xfer_idx == XW'(XFER_BITS - 1)) begin
          mode     <= M_MATCH;
          xfer_idx <= '0;
        end else begin
          xfer_idx <= xfer_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sus_regs.sv
module sus_regs #(
  parameter int NREG     = 8,
  parameter int RW       = 8,
  parameter int LOCK_BYTE = 4,
  parameter int LOCK_BIT  = 4,
  localparam int AW      = $clog2(NREG),
  localparam int BW      = $clog2(RW),
  localparam int XW      = AW + BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [XW-1:0] idx,
  input  logic          d0,
  output logic          rd_bit,
  input  logic [AW-1:0] host_addr,
  output logic [RW-1:0] host_data,
  output logic          rst_lock
);
  logic [RW-1:0] regs [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) regs[g] <= '0;
        else if (wr_en && idx[XW-1:BW] == AW'(g)) regs[g][idx[BW-1:0]] <= d0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bit    <= 1'b0;
      host_data <= '0;
    end else begin
      if (rd_en) rd_bit <= regs[idx[XW-1:BW]][idx[BW-1:0]];
      host_data <= regs[host_addr];
    end
  end

  assign rst_lock = regs[LOCK_BYTE][LOCK_BIT];
endmodule

// File: rtl/snoop_unlock_seq.sv
module snoop_unlock_seq
  import sus_pkg::*;
#(
  parameter int                  KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0] KEY      = KEY_DEFAULT,
  parameter int                  NREG     = 8,
  parameter int                  RW       = 8,
  localparam int                 AW       = $clog2(NREG),
  localparam int                 XFER_BITS = NREG * RW,
  localparam int                 XW       = $clog2(XFER_BITS),
  localparam int                 PW       = $clog2(KEY_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_ce_n,
  input  logic          bus_oe_n,
  input  logic          bus_we_n,
  input  logic          bus_d0_in,
  input  logic          bus_rst_n,
  input  logic          rom_sel,
  input  logic          pwr_fail,
  output logic          mem_ce_n,
  output logic          bus_d0_out,
  output logic          bus_d0_oe,
  input  logic [AW-1:0] rf_addr,
  output logic [RW-1:0] rf_data
);
  logic ce_s, oe_s, we_s, d0_s, nrst_s, pf_s;
  logic fall;
  ev_t  ev;
  logic in_access, miss, xfer_wr, xfer_rd, rd_bit, rst_lock, abort;
  logic [PW-1:0] key_ptr;
  logic [XW-1:0] xfer_idx;
  logic blk, rd_active;

  sus_sync #(.W(5), .RST_VAL(5'b11110)) i_sync (
    .clk(clk), .rst(rst),
    .d({bus_ce_n, bus_oe_n, bus_we_n, bus_rst_n, bus_d0_in}),
    .q({ce_s, oe_s, we_s, nrst_s, d0_s})
  );

  sus_sync #(.W(1), .RST_VAL(1'b0)) i_pf_sync (
    .clk(clk), .rst(rst), .d(pwr_fail), .q(pf_s)
  );

  sus_evt i_evt (
    .clk(clk), .rst(rst), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .fall(fall), .ev(ev)
  );

  assign abort = !nrst_s && !rst_lock;

  sus_ctrl #(.KEY_BITS(KEY_BITS), .KEY(KEY), .XFER_BITS(XFER_BITS)) i_ctrl (
    .clk(clk), .rst(rst), .ev(ev), .d0(d0_s), .abort(abort), .pf(pf_s),
    .in_access(in_access), .key_ptr(key_ptr), .miss(miss),
    .xfer_idx(xfer_idx), .xfer_wr(xfer_wr), .xfer_rd(xfer_rd)
  );

  sus_regs #(.NREG(NREG), .RW(RW)) i_regs (
    .clk(clk), .rst(rst), .wr_en(xfer_wr), .rd_en(xfer_rd), .idx(xfer_idx),
    .d0(d0_s), .rd_bit(rd_bit), .host_addr(rf_addr), .host_data(rf_data),
    .rst_lock(rst_lock)
  );

  // The memory decision for a whole bus cycle is taken when it begins.
  always_ff @(posedge clk) begin
    if (rst) begin
      blk        <= 1'b0;
      rd_active  <= 1'b0;
      mem_ce_n   <= 1'b1;
      bus_d0_out <= 1'b0;
      bus_d0_oe  <= 1'b0;
    end else begin
      if (fall)      blk <= in_access;
      if (fall)      rd_active <= xfer_rd;
      else if (ce_s) rd_active <= 1'b0;
      mem_ce_n   <= pf_s ? ~rom_sel : (ce_s | (fall ? in_access : blk));
      bus_d0_out <= rd_bit;
      bus_d0_oe  <= rd_active & ~ce_s & ~oe_s & ~pf_s;
    end
  end
endmodule

// File: rtl/sus_chk.sv
module sus_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_access,
  input logic          fall,
  input logic          pf_s,
  input logic          rom_sel,
  input logic          mem_ce_n,
  input logic [1:0]    ev,
  input logic [PW-1:0] key_ptr,
  input logic          miss,
  input logic          abort,
  input logic          bus_d0_oe
);
  // R2: a cycle that starts while unlocked never reaches the memory
  p_block_r2: assert property (@(posedge clk) disable iff (rst)
    (in_access && fall && !pf_s) |=> mem_ce_n);

  // R3: a frozen key position stays put on writes
  p_miss_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!in_access && miss && ev == 2'd2 && !abort && !pf_s) |=> $stable(key_ptr));

  // R4: a read while locked restarts the key
  p_read_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (!in_access && ev == 2'd1) |=> (key_ptr == '0));

  // R6: the bit driver and the memory are never both active
  p_no_clash_r6: assert property (@(posedge clk) disable iff (rst)
    bus_d0_oe |-> mem_ce_n);

  // R10: writable memory is shut off during power fail
  p_pf_ram_r10: assert property (@(posedge clk) disable iff (rst)
    (pf_s && !rom_sel) |=> mem_ce_n);

  // R10: read-only memory stays enabled during power fail
  p_pf_rom_r10: assert property (@(posedge clk) disable iff (rst)
    (pf_s && rom_sel) |=> !mem_ce_n);
endmodule

bind snoop_unlock_seq sus_chk #(.PW(PW)) i_chk (
  .clk(clk), .rst(rst), .in_access(in_access), .fall(fall), .pf_s(pf_s),
  .rom_sel(rom_sel), .mem_ce_n(mem_ce_n), .ev(ev), .key_ptr(key_ptr),
  .miss(miss), .abort(abort), .bus_d0_oe(bus_d0_oe)
);

// File: tb/test_snoop_unlock_seq.sv
module test_snoop_unlock_seq;
  logic clk = 0;
  logic rst = 1;
  logic bus_ce_n = 1, bus_oe_n = 1, bus_we_n = 1, bus_d0_in = 0;
  logic bus_rst_n = 1, rom_sel = 0, pwr_fail = 0;
  logic mem_ce_n, bus_d0_out, bus_d0_oe;
  logic [2:0] rf_addr = 0;
  logic [7:0] rf_data;

  int n_run = 0, n_fail = 0, xi = 0;
  logic [7:0] exp_rg [8];
  logic mc, dq, dqe;

  always #4 clk = ~clk;

  snoop_unlock_seq i_snoop_unlock_seq (
    .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_d0_in(bus_d0_in), .bus_rst_n(bus_rst_n),
    .rom_sel(rom_sel), .pwr_fail(pwr_fail), .mem_ce_n(mem_ce_n),
    .bus_d0_out(bus_d0_out), .bus_d0_oe(bus_d0_oe), .rf_addr(rf_addr),
    .rf_data(rf_data)
  );

  function automatic logic key_bit(input int i);
    int b;
    logic [7:0] v;
    b = (i >> 3) % 4;
    v = (b == 0) ? 8'hC5 : (b == 1) ? 8'h3A : (b == 2) ? 8'hA3 : 8'h5C;
    return v[i & 7];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic is_wr, input logic d);
    bus_we_n = !is_wr; bus_oe_n = is_wr; bus_d0_in = d;
    repeat (3) @(negedge clk);
    bus_ce_n = 0;
    repeat (6) @(negedge clk);
    mc = mem_ce_n; dq = bus_d0_out; dqe = bus_d0_oe;
    bus_ce_n = 1;
    repeat (4) @(negedge clk);
    bus_we_n = 1; bus_oe_n = 1;
  endtask

  task automatic key_bits(input int from, input int to, input int flip);
    for (int i = from; i < to; i++) cyc(1, key_bit(i) ^ (i == flip));
  endtask

  task automatic unlock();
    cyc(0, 0);
    key_bits(0, 64, -1);
    xi = 0;
  endtask

  task automatic xw(input logic d);
    exp_rg[xi >> 3][xi & 7] = d;
    cyc(1, d);
    check(mc == 1, "R2 transfer write blocks memory", mc, 1);
    xi++;
  endtask

  task automatic xr();
    logic e;
    e = exp_rg[xi >> 3][xi & 7];
    cyc(0, 0);
    check(dq == e && dqe == 1 && mc == 1, "R6 read transfer bit", {mc, dqe, dq}, {2'b11, e});
    xi++;
  endtask

  task automatic drain();
    while (xi < 64) xr();
  endtask

  task automatic write_bytes(input logic [63:0] v);
    for (int i = 0; i < 64; i++) xw(v[i]);
  endtask

  task automatic expect_locked(input string req);
    cyc(1, 0);
    check(mc == 0, req, mc, 0);
  endtask

  task automatic pulse_rst_pin();
    bus_rst_n = 0; repeat (6) @(negedge clk); bus_rst_n = 1; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    for (int b = 0; b < 8; b++) exp_rg[b] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    check(mem_ce_n == 1 && bus_d0_oe == 0, "R1 reset state", {mem_ce_n, bus_d0_oe}, 2'b10);

    // R1 transparent read and write
    cyc(0, 0); check(mc == 0, "R1 read passes", mc, 0);
    cyc(1, 1); check(mc == 0, "R1 write passes", mc, 0);

    // R2 / R5 / R11: unlock and fill all bytes; byte 4 bit 4 kept 0
    for (int b = 0; b < 8; b++) pat[b*8 +: 8] = 8'(b * 37 + 11);
    pat[36] = 1'b0;
    unlock();
    write_bytes(pat);
    for (int b = 0; b < 8; b++) begin
      rf_addr = 3'(b);
      repeat (2) @(negedge clk);
      check(rf_data == exp_rg[b], "R5 R11 stored byte", rf_data, exp_rg[b]);
    end
    expect_locked("R7 relock after 64 writes");

    // R6: full read back
    unlock(); drain();
    expect_locked("R7 relock after 64 reads");

    // R3: miss freezes, correct key afterwards ignored
    cyc(0, 0);
    key_bits(0, 64, 10);
    key_bits(0, 64, -1);
    expect_locked("R3 writes ignored after miss");
    unlock(); xr(); drain();

    // R4: read restarts the key position
    cyc(0, 0); key_bits(0, 20, -1); cyc(0, 0); key_bits(20, 64, -1);
    expect_locked("R4 read restarted key");
    unlock(); xr(); drain();

    // R8: strobes toggled with chip enable high are not cycles
    cyc(0, 0); key_bits(0, 30, -1);
    for (int k = 0; k < 4; k++) begin
      bus_d0_in = ~key_bit(30);
      bus_we_n = 0; repeat (5) @(negedge clk); bus_we_n = 1;
      bus_oe_n = 0; repeat (5) @(negedge clk); bus_oe_n = 1;
    end
    key_bits(30, 64, -1); xi = 0;
    xr(); check(mc == 1, "R8 unlock despite idle strobes", mc, 1);
    drain();

    // R7: partial transfer stays open, mixed order
    unlock();
    for (int i = 0; i < 10; i++) xw(1'(i & 1));
    xr(); check(mc == 1, "R7 partial session stays open", mc, 1);
    drain();
    expect_locked("R7 relock after mixed transfer");

    // R9: reset pin honoured while byte 4 bit 4 is 0
    unlock(); repeat (5) xr();
    pulse_rst_pin();
    expect_locked("R9 reset pin aborts session");
    pat[36] = 1'b1;
    unlock(); write_bytes(pat);
    unlock(); repeat (3) xr();
    pulse_rst_pin();
    xr(); check(mc == 1, "R9 reset pin ignored when locked out", mc, 1);
    drain();

    // R10: power fail behaviour
    pwr_fail = 1; rom_sel = 0; repeat (4) @(negedge clk);
    cyc(0, 0); check(mc == 1, "R10 ram mode forces high", mc, 1);
    rom_sel = 1; repeat (4) @(negedge clk);
    check(mem_ce_n == 0, "R10 rom mode forces low", mem_ce_n, 0);
    pwr_fail = 0; rom_sel = 0; repeat (4) @(negedge clk);
    unlock(); repeat (2) xr();
    pwr_fail = 1; repeat (6) @(negedge clk); pwr_fail = 0; repeat (4) @(negedge clk);
    expect_locked("R10 power fail ends session");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule